// File: doc/BRIEF.md
# System-Control Coprocessor Register File

This block is a small system-control coprocessor that listens on a simplified coprocessor request port. It claims only requests addressed to coprocessor number 15 and serves register-transfer instructions: a move-from reads one register and a move-to writes one. The register index comes from a field of the instruction word. The block decodes it into an eight-entry space. Entry 0 is a fixed identification word. Entry 1 is a control register whose four defined bits drive the processor's configuration outputs. These outputs select program address width, data address width, abort timing and byte order.

While reset is held, the control bits copy the live configuration input pins. The value on the pins in the last reset cycle is kept. After that, only a move-to to entry 1 changes the control bits. Each such write also raises a one-cycle re-evaluation strobe, so the core re-reads its mode at once. The strobe is raised even when the written value equals the old one. Memory load/store coprocessor transfers are not handled. Neither is address translation.

Top module: `sysctl_cop`

## Requirements
- R1: `req_claim` is high in the same cycle exactly when `req_valid` is high and `req_cpnum` equals 15; otherwise the request is left unclaimed.
- R2: The register index is instruction bits 19:16 masked to three bits, so bit 19 has no effect (index 8 addresses entry 0, index 9 addresses entry 1).
- R3: A claimed read (`req_write`=0) of entry 0 returns 0x41440110 on `rd_data` in the same cycle.
- R4: A claimed read of entry 1 returns the control bits in `rd_data[7:4]` (bit 4 program 32-bit, bit 5 data 32-bit, bit 6 late abort, bit 7 big-endian), with all other bits zero.
- R5: A claimed read of entries 2 to 7 returns zero, and `rd_data` is zero whenever there is no claimed read.
- R6: While `rst_n` is low, the control bits are loaded on every clock from `cfg_in` (`cfg_in[0]`..`cfg_in[3]` map to control bits 4..7). After release they hold the last loaded value, and later changes on `cfg_in` have no effect.
- R7: A claimed write (`req_write`=1) to entry 1 sets `cfg_out` to `req_wdata[7:4]` from the next cycle on (`cfg_out[0]` = bit 4 ... `cfg_out[3]` = bit 7).
- R8: `reeval` is high for exactly the one cycle after each claimed write to entry 1, including repeated writes of an unchanged value and back-to-back writes.
- R9: Writes to entry 0, to entries 2 to 7, and unclaimed writes change neither `cfg_out` nor the identification word, and raise no `reeval`.
- R10: During reset and in the first cycle after release, `reeval` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; control bits follow `cfg_in` while low |
| cfg_in | input | 4 | Configuration pins: [0] program 32-bit, [1] data 32-bit, [2] late abort, [3] big-endian |
| req_valid | input | 1 | A coprocessor register transfer is offered this cycle |
| req_cpnum | input | 4 | Coprocessor number of the offered transfer |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_instr | input | 32 | Instruction word; bits 19:16 carry the register index |
| req_wdata | input | 32 | Data for a move-to |
| req_claim | output | 1 | The block accepts the offered transfer |
| rd_data | output | 32 | Read data for a claimed move-from; zero otherwise |
| cfg_out | output | 4 | Configuration outputs, same bit order as `cfg_in` |
| reeval | output | 1 | One-cycle strobe after a control-register write |

## Verification
The assertions assume that the request inputs are settled, with no X, before each rising edge. They also assume that a request lasts one cycle: every cycle with `req_valid` high counts as a new transfer. The bench changes all inputs only on the falling clock edge and gives each transfer exactly one cycle. Back-to-back writes are offered on purpose, because every valid cycle is a transfer. Reset is driven on the falling edge as well, so the last `cfg_in` value sampled during reset is well defined.

// File: rtl/sysctl_cop_pkg.sv
package sysctl_cop_pkg;
  localparam int DATA_W   = 32;
  localparam int CPN_W    = 4;
  localparam int IDX_FLD_W = 4;
  localparam int IDX_LSB  = 16;
  localparam int IDX_W    = 3;
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int CFG_W    = 4;
  localparam int CFG_LSB  = 4;
  localparam logic [CPN_W-1:0]  OWN_CPNUM = 4'd15;
  localparam logic [DATA_W-1:0] ID_WORD   = 32'h4144_0110;
  localparam logic [IDX_W-1:0]  ENT_ID    = 3'd0;
  localparam logic [IDX_W-1:0]  ENT_CTRL  = 3'd1;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CFG_W-1:0]  cfg_t;
  typedef logic [DATA_W-1:0] word_t;

  // Index extraction: instruction field masked down to the entry count.
  function automatic idx_t field_to_idx(input logic [IDX_FLD_W-1:0] fld);
    return fld[IDX_W-1:0];
  endfunction

  // Value seen when reading entry e with control bits c.
  function automatic word_t entry_value(input int e, input cfg_t c);
    word_t v;
    v = '0;
    if (e == int'(ENT_ID))        v = ID_WORD;
    else if (e == int'(ENT_CTRL)) v[CFG_LSB +: CFG_W] = c;
    return v;
  endfunction
endpackage

// File: rtl/sysctl_cop_decode.sv
module sysctl_cop_decode
  import sysctl_cop_pkg::*;
(
  input  logic                 req_valid,
  input  logic [CPN_W-1:0]     req_cpnum,
  input  logic                 req_write,
  input  logic [IDX_FLD_W-1:0] idx_field,
  output logic                 claim,
  output logic                 rd_acc,
  output logic                 wr_ctrl,
  output idx_t                 idx
);
  always_comb begin
    claim   = req_valid && (req_cpnum == OWN_CPNUM);
    idx     = field_to_idx(idx_field);
    rd_acc  = claim && !req_write;
    wr_ctrl = claim && req_write && (idx == ENT_CTRL);
  end
endmodule

// File: rtl/sysctl_cop_ctrl.sv
module sysctl_cop_ctrl
  import sysctl_cop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_in,
  input  logic wr_ctrl,
  input  cfg_t wr_bits,
  output cfg_t cfg_q,
  output logic reeval
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= cfg_in;
      reeval <= 1'b0;
    end else begin
      if (wr_ctrl) cfg_q <= wr_bits;
      reeval <= wr_ctrl;
    end
  end
endmodule

// File: rtl/sysctl_cop_rdmux.sv
module sysctl_cop_rdmux
  import sysctl_cop_pkg::*;
(
  input  logic  rd_acc,
  input  idx_t  idx,
  input  cfg_t  cfg_q,
  output word_t rd_data
);
  word_t ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ent[g] = entry_value(g, cfg_q);
  end

  always_comb begin
    rd_data = rd_acc ? ent[idx] : '0;
  end
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sysctl_cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic              req_valid,
  input  logic [CPN_W-1:0]  req_cpnum,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_instr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_claim,
  output logic [DATA_W-1:0] rd_data,
  output logic [CFG_W-1:0]  cfg_out,
  output logic              reeval
);
  logic claim_w;
  logic rd_acc_w;
  logic wr_ctrl_w;
  idx_t idx_w;
  cfg_t cfg_q;

  logic unused_bits;
  assign unused_bits = ^{req_instr[DATA_W-1:IDX_LSB+IDX_FLD_W],
                         req_instr[IDX_LSB-1:0],
                         req_wdata[DATA_W-1:CFG_LSB+CFG_W],
                         req_wdata[CFG_LSB-1:0]};

  sysctl_cop_decode u_dec (
    .req_valid (req_valid),
    .req_cpnum (req_cpnum),
    .req_write (req_write),
    .idx_field (req_instr[IDX_LSB +: IDX_FLD_W]),
    .claim     (claim_w),
    .rd_acc    (rd_acc_w),
    .wr_ctrl   (wr_ctrl_w),
    .idx       (idx_w)
  );

  sysctl_cop_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_in  (cfg_in),
    .wr_ctrl (wr_ctrl_w),
    .wr_bits (req_wdata[CFG_LSB +: CFG_W]),
    .cfg_q   (cfg_q),
    .reeval  (reeval)
  );

  sysctl_cop_rdmux u_rd (
    .rd_acc  (rd_acc_w),
    .idx     (idx_w),
    .cfg_q   (cfg_q),
    .rd_data (rd_data)
  );

  assign req_claim = claim_w;
  assign cfg_out   = cfg_q;
endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk
  import sysctl_cop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CPN_W-1:0]  req_cpnum,
  input logic              req_write,
  input logic [DATA_W-1:0] req_instr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_claim,
  input logic [DATA_W-1:0] rd_data,
  input logic [CFG_W-1:0]  cfg_out,
  input logic              reeval,
  input logic              wr_ctrl_w
);
  logic       port_hit;
  logic [2:0] port_idx;
  assign port_hit = req_valid && (req_cpnum == 4'd15);
  assign port_idx = req_instr[18:16];

  AST_NO_FOREIGN_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_cpnum != 4'd15) |-> !req_claim); // R1
  AST_OWN_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |-> req_claim); // R1
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && !req_write && port_idx == 3'd0) |-> rd_data == 32'h4144_0110); // R3
  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && !req_write && port_idx == 3'd1) |-> (rd_data == {24'h0, cfg_out, 4'h0})); // R4
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_hit || req_write) |-> rd_data == '0); // R5
  AST_CFG_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && req_write && port_idx == 3'd1) |=> cfg_out == $past(req_wdata[7:4])); // R7
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && reeval) |-> $past(port_hit && req_write && port_idx == 3'd1)); // R8
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_w |=> reeval); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_ctrl_w)) |-> $stable(cfg_out)); // R9
  AST_NO_STROBE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !reeval); // R10
endmodule

bind sysctl_cop sysctl_cop_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_cpnum (req_cpnum),
  .req_write (req_write),
  .req_instr (req_instr),
  .req_wdata (req_wdata),
  .req_claim (req_claim),
  .rd_data   (rd_data),
  .cfg_out   (cfg_out),
  .reeval    (reeval),
  .wr_ctrl_w (wr_ctrl_w)
);

// File: tb/sysctl_cop_bench.sv
`timescale 1ns/100ps
module sysctl_cop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_in = 4'h0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cpnum = 4'h0;
  logic        req_write = 1'b0;
  logic [31:0] req_instr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_claim;
  logic [31:0] rd_data;
  logic [3:0]  cfg_out;
  logic        reeval;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state
  logic [3:0] m_cfg   = 4'h0;
  logic       m_pulse = 1'b0;
  bit         m_known = 0;

  always #2.5 clk = ~clk;

  sysctl_cop u_sysctl_cop (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
    .req_valid(req_valid), .req_cpnum(req_cpnum), .req_write(req_write),
    .req_instr(req_instr), .req_wdata(req_wdata),
    .req_claim(req_claim), .rd_data(rd_data), .cfg_out(cfg_out), .reeval(reeval)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] fld, input logic [3:0] c);
    int e;
    e = fld % 8;
    case (e)
      0: return 32'h4144_0110;
      1: return {24'h0, c, 4'h0};
      default: return 32'h0;
    endcase
  endfunction

  // One clock cycle: check registered outputs, drive inputs, check
  // same-cycle outputs, then advance the model past the rising edge.
  task automatic cyc(input bit rst, input logic [3:0] pins, input bit v,
                     input logic [3:0] cp, input bit wr, input logic [3:0] fld,
                     input logic [31:0] wd, input string tag);
    bit          hit;
    logic [31:0] exp_rd;
    @(negedge clk);
    if (m_known) begin
      check(cfg_out === m_cfg, tag, "cfg_out", {28'h0, cfg_out}, {28'h0, m_cfg});
      check(reeval === m_pulse, tag, "reeval", {31'h0, reeval}, {31'h0, m_pulse});
    end
    rst_n     = !rst;
    cfg_in    = pins;
    req_valid = v;
    req_cpnum = cp;
    req_write = wr;
    req_instr = {12'hABC, fld, 16'h5A5A};
    req_wdata = wd;
    #1;
    hit    = v && (cp == 4'd15);
    exp_rd = (hit && !wr) ? model_read(fld, m_cfg) : 32'h0;
    if (!rst) begin
      check(req_claim === hit, "R1", "req_claim", {31'h0, req_claim}, {31'h0, hit});
      check(rd_data === exp_rd, tag, "rd_data", rd_data, exp_rd);
    end
    if (rst) begin
      m_cfg   = pins;
      m_pulse = 1'b0;
      m_known = 1;
    end else if (hit && wr && (fld % 8) == 1) begin
      m_cfg   = wd[7:4];
      m_pulse = 1'b1;
    end else begin
      m_pulse = 1'b0;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #50000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x00000000 expected 0x00000001");
      summary();
    end
  end

  initial begin
    // R6 / R10: reset loads live pins; last reset cycle wins
    cyc(1, 4'h3, 0, 4'd0, 0, 4'd0, 0, "R10");
    cyc(1, 4'h3, 0, 4'd0, 0, 4'd0, 0, "R10");
    cyc(1, 4'hA, 0, 4'd0, 0, 4'd0, 0, "R6");
    cyc(0, 4'h5, 0, 4'd0, 0, 4'd0, 0, "R10");
    cyc(0, 4'h5, 0, 4'd0, 0, 4'd0, 0, "R6");
    cyc(0, 4'hF, 1, 4'd15, 0, 4'd1, 0, "R6");
    // reads
    cyc(0, 4'hF, 1, 4'd15, 0, 4'd0, 0, "R3");
    cyc(0, 4'hF, 1, 4'd15, 0, 4'd8, 0, "R2");
    cyc(0, 4'hF, 1, 4'd15, 0, 4'd1, 0, "R4");
    cyc(0, 4'hF, 1, 4'd15, 0, 4'd9, 0, "R2");
    for (int k = 2; k < 8; k++) cyc(0, 4'h0, 1, 4'd15, 0, 4'(k), 0, "R5");
    cyc(0, 4'h0, 1, 4'd14, 0, 4'd0, 0, "R1");
    cyc(0, 4'h0, 0, 4'd15, 0, 4'd0, 0, "R1");
    cyc(0, 4'h0, 1, 4'd5, 0, 4'd1, 0, "R5");
    // writes to control entry
    cyc(0, 4'h0, 1, 4'd15, 1, 4'd1, 32'hFFFF_FF5F, "R7");
    cyc(0, 4'h0, 0, 4'd0, 0, 4'd0, 0, "R8");
    cyc(0, 4'h0, 1, 4'd15, 0, 4'd1, 0, "R4");
    cyc(0, 4'h0, 1, 4'd15, 1, 4'd1, 32'h0000_0050, "R8");
    cyc(0, 4'h0, 1, 4'd15, 1, 4'd1, 32'h0000_00C0, "R8");
    cyc(0, 4'h0, 1, 4'd15, 1, 4'd9, 32'h0000_0030, "R2");
    cyc(0, 4'h0, 0, 4'd0, 0, 4'd0, 0, "R8");
    // ignored writes
    cyc(0, 4'h0, 1, 4'd15, 1, 4'd0, 32'hFFFF_FFFF, "R9");
    cyc(0, 4'h0, 1, 4'd15, 0, 4'd0, 0, "R9");
    for (int k = 2; k < 8; k++) cyc(0, 4'h0, 1, 4'd15, 1, 4'(k), 32'hFFFF_FFF0, "R9");
    cyc(0, 4'h0, 1, 4'd14, 1, 4'd1, 32'hFFFF_FFF0, "R9");
    cyc(0, 4'h0, 0, 4'd15, 1, 4'd1, 32'hFFFF_FFF0, "R9");
    cyc(0, 4'h0, 1, 4'd15, 0, 4'd1, 0, "R9");
    // write then reset: reset wins, pulse cleared
    cyc(0, 4'h0, 1, 4'd15, 1, 4'd1, 32'h0000_00F0, "R7");
    cyc(1, 4'h6, 0, 4'd0, 0, 4'd0, 0, "R10");
    cyc(0, 4'h9, 0, 4'd0, 0, 4'd0, 0, "R10");
    cyc(0, 4'h9, 1, 4'd15, 0, 4'd1, 0, "R6");
    cyc(0, 4'h9, 0, 4'd0, 0, 4'd0, 0, "R6");
    finished = 1;
    summary();
  end
endmodule